// File: doc/BRIEF.md
# Parallel Port Bus Interface Controller

This block is the processor-facing side of a three-port parallel I/O device. A processor reaches it through an 8-bit data bus, a chip select, read and write strobes and two address lines. All three control inputs are active low. The bus appears here as its two halves: the incoming data and the outgoing data with a drive enable. Each access goes to port A, port B, port C or the control register. The block keeps the output latches of the three ports and the configuration word. It also drives the direction enables of the four port groups: port A, port B, upper port C and lower port C.

A byte written to the control address is one of two commands. If its top bit is set, it is a configuration word. This word fixes the direction of each group and the group A and group B operating modes. If its top bit is clear, it is a single-bit command. This command sets or clears one port C latch bit, chosen by a three-bit index, and touches nothing else. The operating-mode bits are passed to the handshake logic outside this block.

Top module: `ppi_bus_ctrl`

## Requirements
- R1: With `cs_n` low, a write to `addr` 0, 1 or 2 loads `bus_din` into the port A, B or C latch. Each write takes effect once, at the first rising clock edge that sees `cs_n` and `wr_n` both low. Ports `pa_out`/`pb_out`/`pc_out` show the latches whatever the directions are.
- R2: While `cs_n` is high, writes change nothing and `bus_oe` stays low.
- R3: `bus_oe` is high exactly while `cs_n` and `rd_n` are both low. The read data appears in the same cycle, with no clock edge needed.
- R4: After reset (`rst` high, synchronous), every direction enable is low (all groups input), all latches are 0 and both mode outputs are 0.
- R5: A control write with bit 7 = 1 is a configuration word. Bit 4 sets the port A direction, bit 3 upper port C, bit 1 port B and bit 0 lower port C, with 1 = input. An output group drives its enable high.
- R6: In a configuration word, bits 6:5 give `grpa_mode` and bit 2 gives `grpb_mode`.
- R7: Writing a configuration word clears all three output latches to 0.
- R8: A control write with bit 7 = 0 loads bit 0 into port C latch bit number bits 3:1 (for example, 0x09 sets bit 4 and 0x08 clears it). No other port C bit changes.
- R9: A single-bit command leaves the port A and B latches, the directions and the modes unchanged.
- R10: A read of ports A, B or C returns the pins for an input group and the latch for an output group. Each nibble of port C is chosen separately.
- R11: A read of the control address returns bit 7 = 1 with the stored configuration in bits 6:0. After reset this reads 0x9B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select: 0 A, 1 B, 2 C, 3 control |
| bus_din | input | 8 | Data bus, processor to block |
| bus_dout | output | 8 | Data bus, block to processor |
| bus_oe | output | 1 | Data bus drive enable |
| pa_in | input | 8 | Port A pins |
| pb_in | input | 8 | Port B pins |
| pc_in | input | 8 | Port C pins |
| pa_out | output | 8 | Port A latch |
| pb_out | output | 8 | Port B latch |
| pc_out | output | 8 | Port C latch |
| pa_oe | output | 1 | Port A drives its pins |
| pb_oe | output | 1 | Port B drives its pins |
| pc_oe | output | 8 | Per-bit port C drive enables (upper and lower nibble groups) |
| grpa_mode | output | 2 | Group A operating mode |
| grpb_mode | output | 1 | Group B operating mode |

## Verification
Reads are combinational. The bench applies the address and strobes on a falling clock edge and samples `bus_dout` and `bus_oe` shortly afterwards, in the same low phase. A write commits at the next rising edge. The latch, direction and mode outputs are therefore sampled on the falling edge after that rising edge, once the strobe has been released. The bench sweeps all sixteen direction combinations and all sixteen single-bit commands. It computes every expected latch, enable and read value from the written bytes and the pin values.

// File: rtl/ppi_bus_ctrl.sv
module ppi_bus_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [1:0] addr,
  input  logic [7:0] bus_din,
  output logic [7:0] bus_dout,
  output logic       bus_oe,
  input  logic [7:0] pa_in,
  input  logic [7:0] pb_in,
  input  logic [7:0] pc_in,
  output logic [7:0] pa_out,
  output logic [7:0] pb_out,
  output logic [7:0] pc_out,
  output logic       pa_oe,
  output logic       pb_oe,
  output logic [7:0] pc_oe,
  output logic [1:0] grpa_mode,
  output logic       grpb_mode
);

  localparam logic [6:0] CFG_RESET = 7'h1B;

  logic [6:0] cfg;
  logic [7:0] lat_a, lat_b, lat_c;
  logic       wr_seen;
  logic       wr_act, wr_fire;

  assign wr_act  = !cs_n && !wr_n;
  assign wr_fire = wr_act && !wr_seen;

  always_ff @(posedge clk) begin
    if (rst) wr_seen <= 1'b0;
    else     wr_seen <= wr_act;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg   <= CFG_RESET;
      lat_a <= '0;
      lat_b <= '0;
      lat_c <= '0;
    end else if (wr_fire) begin
      case (addr)
        2'd0: lat_a <= bus_din;
        2'd1: lat_b <= bus_din;
        2'd2: lat_c <= bus_din;
        default: begin
          if (bus_din[7]) begin
            cfg   <= bus_din[6:0];
            lat_a <= '0;
            lat_b <= '0;
            lat_c <= '0;
          end else begin
            lat_c[bus_din[3:1]] <= bus_din[0];
          end
        end
      endcase
    end
  end

  logic a_in, b_in, cu_in, cl_in;
  assign a_in  = cfg[4];
  assign cu_in = cfg[3];
  assign b_in  = cfg[1];
  assign cl_in = cfg[0];

  assign pa_out    = lat_a;
  assign pb_out    = lat_b;
  assign pc_out    = lat_c;
  assign pa_oe     = !a_in;
  assign pb_oe     = !b_in;
  assign pc_oe     = {{4{!cu_in}}, {4{!cl_in}}};
  assign grpa_mode = cfg[6:5];
  assign grpb_mode = cfg[2];

  assign bus_oe = !cs_n && !rd_n;

  always_comb begin
    case (addr)
      2'd0:    bus_dout = a_in ? pa_in : lat_a;
      2'd1:    bus_dout = b_in ? pb_in : lat_b;
      2'd2:    bus_dout = {cu_in ? pc_in[7:4] : lat_c[7:4],
                           cl_in ? pc_in[3:0] : lat_c[3:0]};
      default: bus_dout = {1'b1, cfg};
    endcase
  end

  p_idle_no_write_r2: assert property (@(posedge clk) disable iff (rst)
    (cs_n && !rst) |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out)));

  p_idle_no_drive_r2: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !bus_oe);

  p_cfg_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && addr == 2'd3 && bus_din[7]) |=> (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00));

  p_bit_cmd_one_bit_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && addr == 2'd3 && !bus_din[7]) |=> ($countones(pc_out ^ $past(pc_out)) <= 1));

  p_bit_cmd_keeps_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && addr == 2'd3 && !bus_din[7]) |=>
      ($stable(pa_out) && $stable(pb_out) && $stable(pa_oe) && $stable(pb_oe) &&
       $stable(pc_oe) && $stable(grpa_mode) && $stable(grpb_mode)));

  p_held_strobe_once_r1: assert property (@(posedge clk) disable iff (rst)
    (wr_act && $past(wr_act) && !$past(rst)) |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out)));

endmodule

// File: tb/test_ppi_bus_ctrl.sv
module test_ppi_bus_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] bus_din = '0;
  logic [7:0] bus_dout;
  logic       bus_oe;
  logic [7:0] pa_in = '0, pb_in = '0, pc_in = '0;
  logic [7:0] pa_out, pb_out, pc_out, pc_oe;
  logic       pa_oe, pb_oe, grpb_mode;
  logic [1:0] grpa_mode;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  ppi_bus_ctrl i_ppi_bus_ctrl (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .pa_in(pa_in), .pb_in(pb_in), .pc_in(pc_in),
    .pa_out(pa_out), .pb_out(pb_out), .pc_out(pc_out),
    .pa_oe(pa_oe), .pb_oe(pb_oe), .pc_oe(pc_oe),
    .grpa_mode(grpa_mode), .grpb_mode(grpb_mode));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; addr = a; bus_din = d;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; addr = a;
    #1;
    d = bus_dout; oe = bus_oe;
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic oe;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R4 reset state
    check("R4 pa_oe", pa_oe, 0);
    check("R4 pb_oe", pb_oe, 0);
    check("R4 pc_oe", pc_oe, 0);
    check("R4 latches", {pa_out, pb_out, pc_out}, 0);
    check("R4 modes", {grpa_mode, grpb_mode}, 0);
    rd(2'd3, d, oe);
    check("R11 reset cfg read", d, 8'h9B);
    check("R3 oe on read", oe, 1);
    @(negedge clk);
    check("R3 oe idle", bus_oe, 0);

    // R5 R7 R10 R1 sweep over direction combinations
    for (int k = 0; k < 16; k++) begin
      logic [7:0] cw;
      logic ai, cui, bi, cli;
      logic [7:0] ea, eb, ec;
      ai = k[3]; cui = k[2]; bi = k[1]; cli = k[0];
      cw = {1'b1, 2'b00, ai, cui, 1'b0, bi, cli};
      wr(2'd1, 8'hFF);
      wr(2'd3, cw);
      check("R5 pa_oe", pa_oe, !ai);
      check("R5 pb_oe", pb_oe, !bi);
      check("R5 pc_oe", pc_oe, {{4{!cui}}, {4{!cli}}});
      check("R7 latches cleared", {pa_out, pb_out, pc_out}, 0);
      ea = 8'h11 * k[3:0] ^ 8'h5A;
      eb = 8'hA5 + k[7:0];
      ec = 8'h3C ^ (k[7:0] << 2);
      wr(2'd0, ea); wr(2'd1, eb); wr(2'd2, ec);
      check("R1 pa latch", pa_out, ea);
      check("R1 pb latch", pb_out, eb);
      check("R1 pc latch", pc_out, ec);
      pa_in = 8'hC3 ^ k[7:0]; pb_in = 8'h96 + k[7:0]; pc_in = 8'h69 ^ (k[7:0] << 4);
      rd(2'd0, d, oe);
      check("R10 read A", d, ai ? pa_in : ea);
      rd(2'd1, d, oe);
      check("R10 read B", d, bi ? pb_in : eb);
      rd(2'd2, d, oe);
      check("R10 read C", d, {cui ? pc_in[7:4] : ec[7:4], cli ? pc_in[3:0] : ec[3:0]});
      rd(2'd3, d, oe);
      check("R11 cfg read", d, cw);
    end

    // R6 mode fields
    wr(2'd3, 8'hE4);
    check("R6 grpa_mode 3", grpa_mode, 2'd3);
    check("R6 grpb_mode 1", grpb_mode, 1'b1);
    wr(2'd3, 8'hC0);
    check("R6 grpa_mode 2", grpa_mode, 2'd2);
    check("R6 grpb_mode 0", grpb_mode, 1'b0);

    // R8 R9 single-bit command sweep
    wr(2'd3, 8'hA0);
    wr(2'd0, 8'h77); wr(2'd1, 8'h88); wr(2'd2, 8'h00);
    begin
      logic [7:0] ec;
      ec = 8'h00;
      for (int v = 1; v >= 0; v--) begin
        for (int i = 0; i < 8; i++) begin
          wr(2'd3, {4'b0000, i[2:0], v[0]});
          ec[i] = v[0];
          check("R8 pc bit", pc_out, ec);
          check("R9 A B kept", {pa_out, pb_out}, 16'h7788);
          check("R9 mode kept", {grpa_mode, grpb_mode, pa_oe, pb_oe, pc_oe}, {2'd1, 1'b0, 1'b1, 1'b1, 8'hFF});
        end
      end
    end
    wr(2'd3, 8'h09);
    check("R8 0x09 sets bit4", pc_out, 8'h10);
    wr(2'd3, 8'h08);
    check("R8 0x08 clears bit4", pc_out, 8'h00);

    // R2 deselected accesses
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b0; addr = 2'd0; bus_din = 8'hEE;
    @(negedge clk);
    @(negedge clk);
    wr_n = 1'b1;
    check("R2 no write when deselected", pa_out, 8'h77);
    @(negedge clk);
    rd_n = 1'b0; #1;
    check("R2 no drive when deselected", bus_oe, 0);
    rd_n = 1'b1;

    // R1 held strobe commits once
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; addr = 2'd3; bus_din = 8'h05;
    @(negedge clk);
    bus_din = 8'h04;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
    check("R1 held strobe once", pc_out, 8'h04);

    // R4 reset again
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R4 reset clears", {pa_out, pb_out, pc_out, pc_oe}, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule